// File: doc/BRIEF.md
# Condition-Flag Branch Target Resolver

This block takes the leading bytes of a branch instruction, the address of that instruction and the four condition flags (zero, negative, carry, overflow). From them it works out whether the branch is taken and what the next program counter is. Two encodings are recognised. The first is a two-byte relative branch that covers signed, unsigned and equality conditions, plus one unconditional form. The second is a three-byte form behind a prefix byte that tests the overflow, carry and negative flags. Every displacement is a signed byte. It is added to the address of the first byte of the instruction, not to the address that follows it.

A caller presents an instruction together with a one-cycle `valid_i` strobe. One cycle later `valid_o` pulses and the result appears on the outputs. If the opcode is not one of the recognised branches, the block lowers `is_branch_o` and reports the sequential address. All address arithmetic wraps modulo 2^AW.

Top module: `branch_resolver`

## Requirements
- R1: After reset `valid_o`, `is_branch_o` and `taken_o` are 0 and `target_o` is 0.
- R2: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i` = 1, and the other outputs carry the result for that input.
- R3: Byte-0 values 0xC0..0xCA are two-byte branches. They give `is_branch_o` = 1, and byte 1 holds the displacement.
- R4: Signed short conditions, with lt = N^V: 0xC0 lt; 0xC2 not lt; 0xC3 le = Z|lt; 0xC1 not le.
- R5: Unsigned and equality short conditions: 0xC4 C; 0xC6 not C; 0xC7 C|Z; 0xC5 not (C|Z); 0xC8 Z; 0xC9 not Z.
- R6: 0xCA is taken for every flag combination.
- R7: Byte 0 = 0xF8 followed by byte 1 = 0xE8 (V=0), 0xE9 (V=1), 0xEA (C=0) or 0xEB (N=1) is a three-byte branch with its displacement in byte 2.
- R8: A taken branch targets `pc_i` plus the displacement sign-extended from 8 bits, modulo 2^AW.
- R9: A recognised branch that is not taken targets `pc_i` + 2 for the short form and `pc_i` + 3 for the long form, modulo 2^AW.
- R10: Any other opcode, including 0xCB..0xCF and 0xF8 with any other byte 1, gives `is_branch_o` = 0, `taken_o` = 0 and `target_o` = `pc_i` + 2.
- R11: While `valid_i` is 0, `is_branch_o`, `taken_o` and `target_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| op0_i | input | 8 | First instruction byte |
| op1_i | input | 8 | Second instruction byte |
| op2_i | input | 8 | Third instruction byte |
| pc_i | input | AW | Address of the instruction |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| valid_o | output | 1 | Result strobe |
| is_branch_o | output | 1 | Opcode is a recognised branch |
| taken_o | output | 1 | Branch is taken |
| target_o | output | AW | Next program counter |

## Verification
Every result is due exactly one clock edge after the strobe that carries its inputs. The bench drives each vector on a falling edge, drops the strobe on the next falling edge and compares all outputs at that same point. After one further idle cycle it confirms that `valid_o` is 0 and that the other outputs have not changed. All 256 first-byte values and all 256 second-byte values behind the prefix are swept against all 16 flag combinations. Displacement sweeps near both ends of the address space exercise the wraparound.

// File: rtl/br_res_pkg.sv
package br_res_pkg;
  // Short-form codes equal the low nibble of byte 0.
  typedef enum logic [3:0] {
    CND_LT = 4'd0, CND_GT = 4'd1, CND_GE = 4'd2, CND_LE = 4'd3,
    CND_CS = 4'd4, CND_HI = 4'd5, CND_CC = 4'd6, CND_LS = 4'd7,
    CND_EQ = 4'd8, CND_NE = 4'd9, CND_RA = 4'd10,
    CND_VC = 4'd11, CND_VS = 4'd12, CND_NC = 4'd13, CND_NS = 4'd14,
    CND_NONE = 4'd15
  } cond_e;

  localparam logic [7:0] SHORT_ROW   = 8'hC0;
  localparam logic [7:0] SHORT_LAST  = 8'hCA;
  localparam logic [7:0] LONG_PFX    = 8'hF8;
  localparam logic [5:0] LONG_ROW    = 6'b111010;

  typedef struct packed {
    logic flag_z;
    logic flag_n;
    logic flag_c;
    logic flag_v;
  } flags_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_res_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] op0_i,
  input  logic [OPW-1:0] op1_i,
  input  logic [OPW-1:0] op2_i,
  output cond_e          cond_o,
  output logic           is_br_o,
  output logic           long_o,
  output logic [OPW-1:0] disp_o
);
  logic short_hit, long_hit;

  assign short_hit = (op0_i[OPW-1:4] == SHORT_ROW[7:4]) && (op0_i[3:0] <= SHORT_LAST[3:0]);
  assign long_hit  = (op0_i == LONG_PFX) && (op1_i[OPW-1:2] == LONG_ROW);

  always_comb begin
    cond_o = CND_NONE;
    if (short_hit)     cond_o = cond_e'(op0_i[3:0]);
    else if (long_hit) cond_o = cond_e'(4'd11 + {2'b00, op1_i[1:0]});
  end

  assign is_br_o = short_hit | long_hit;
  assign long_o  = long_hit;
  assign disp_o  = long_hit ? op2_i : op1_i;
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_res_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   taken_o
);
  logic lt, le, ls;

  assign lt = flags_i.flag_n ^ flags_i.flag_v;
  assign le = flags_i.flag_z | lt;
  assign ls = flags_i.flag_c | flags_i.flag_z;

  always_comb begin
    unique case (cond_i)
      CND_LT:  taken_o = lt;
      CND_GT:  taken_o = ~le;
      CND_GE:  taken_o = ~lt;
      CND_LE:  taken_o = le;
      CND_CS:  taken_o = flags_i.flag_c;
      CND_HI:  taken_o = ~ls;
      CND_CC:  taken_o = ~flags_i.flag_c;
      CND_LS:  taken_o = ls;
      CND_EQ:  taken_o = flags_i.flag_z;
      CND_NE:  taken_o = ~flags_i.flag_z;
      CND_RA:  taken_o = 1'b1;
      CND_VC:  taken_o = ~flags_i.flag_v;
      CND_VS:  taken_o = flags_i.flag_v;
      CND_NC:  taken_o = ~flags_i.flag_c;
      CND_NS:  taken_o = flags_i.flag_n;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int AW  = 32,
  parameter int OPW = 8
) (
  input  logic [AW-1:0]  pc_i,
  input  logic [OPW-1:0] disp_i,
  input  logic           long_i,
  input  logic           taken_i,
  output logic [AW-1:0]  target_o
);
  localparam int EXT = AW - OPW;

  logic [AW-1:0] disp_ext, step;

  assign disp_ext = {{EXT{disp_i[OPW-1]}}, disp_i};
  // Non-branches reuse the short fall-through step.
  assign step     = taken_i ? disp_ext : (long_i ? AW'(3) : AW'(2));
  assign target_o = pc_i + step;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_res_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OPW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [OPW-1:0] op0_i,
  input  logic [OPW-1:0] op1_i,
  input  logic [OPW-1:0] op2_i,
  input  logic [AW-1:0]  pc_i,
  input  logic           flag_z_i,
  input  logic           flag_n_i,
  input  logic           flag_c_i,
  input  logic           flag_v_i,
  output logic           valid_o,
  output logic           is_branch_o,
  output logic           taken_o,
  output logic [AW-1:0]  target_o
);
  cond_e          cond;
  logic           is_br, long_f, cond_true, taken;
  logic [OPW-1:0] disp;
  logic [AW-1:0]  target;
  flags_t         flags;

  assign flags = '{flag_z: flag_z_i, flag_n: flag_n_i, flag_c: flag_c_i, flag_v: flag_v_i};

  br_decode #(.OPW(OPW)) u_dec (
    .op0_i  (op0_i),
    .op1_i  (op1_i),
    .op2_i  (op2_i),
    .cond_o (cond),
    .is_br_o(is_br),
    .long_o (long_f),
    .disp_o (disp)
  );

  br_cond_eval u_cond (
    .cond_i (cond),
    .flags_i(flags),
    .taken_o(cond_true)
  );

  assign taken = is_br & cond_true;

  br_target #(.AW(AW), .OPW(OPW)) u_tgt (
    .pc_i    (pc_i),
    .disp_i  (disp),
    .long_i  (long_f),
    .taken_i (taken),
    .target_o(target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      is_branch_o <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        is_branch_o <= is_br;
        taken_o     <= taken;
        target_o    <= target;
      end
    end
  end
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int AW  = 32,
  parameter int OPW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [OPW-1:0] op0_i,
  input logic [AW-1:0]  pc_i,
  input logic           flag_z_i,
  input logic           valid_o,
  input logic           is_branch_o,
  input logic           taken_o,
  input logic [AW-1:0]  target_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(target_o) && $stable(taken_o) && $stable(is_branch_o)));
  a_r10_no_take_non_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !is_branch_o) |-> !taken_o);
  a_r6_always_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op0_i == 8'hCA) |=> (taken_o && is_branch_o));
  a_r5_eq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op0_i == 8'hC8 && flag_z_i) |=> taken_o);
  a_r10_seq_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op0_i == 8'hCB) |=> (target_o == $past(pc_i) + AW'(2)));
endmodule

bind branch_resolver br_resolver_chk #(.AW(AW), .OPW(OPW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op0_i      (op0_i),
  .pc_i       (pc_i),
  .flag_z_i   (flag_z_i),
  .valid_o    (valid_o),
  .is_branch_o(is_branch_o),
  .taken_o    (taken_o),
  .target_o   (target_o)
);

// File: tb/tb_branch_resolver.sv
`timescale 1ns/1ps
module tb_branch_resolver;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [7:0]    op0_i = '0, op1_i = '0, op2_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic          flag_z_i = 0, flag_n_i = 0, flag_c_i = 0, flag_v_i = 0;
  logic          valid_o, is_branch_o, taken_o;
  logic [AW-1:0] target_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  branch_resolver #(.AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference from the requirements: returns is_branch, taken, target.
  task automatic model(input logic [7:0] b0, b1, b2, input logic [AW-1:0] pc,
                       input logic [3:0] f, output bit isb, output bit tk, output logic [AW-1:0] tgt);
    bit z, n, c, v, sgn_lt;
    logic [7:0] d;
    int len;
    {z, n, c, v} = f;
    sgn_lt = n ^ v;
    isb = 1; len = 2; d = b1; tk = 0;
    case (b0)
      8'hC0: tk = sgn_lt;
      8'hC1: tk = !(z || sgn_lt);
      8'hC2: tk = !sgn_lt;
      8'hC3: tk = z || sgn_lt;
      8'hC4: tk = c;
      8'hC5: tk = !(c || z);
      8'hC6: tk = !c;
      8'hC7: tk = c || z;
      8'hC8: tk = z;
      8'hC9: tk = !z;
      8'hCA: tk = 1;
      8'hF8: begin
        len = 3; d = b2;
        case (b1)
          8'hE8: tk = !v;
          8'hE9: tk = v;
          8'hEA: tk = !c;
          8'hEB: tk = n;
          default: begin isb = 0; len = 2; end
        endcase
      end
      default: isb = 0;
    endcase
    if (tk) tgt = pc + AW'($signed(d));
    else    tgt = pc + AW'(len);
  endtask

  task automatic run(input logic [7:0] b0, b1, b2, input logic [AW-1:0] pc,
                     input logic [3:0] f, input string req);
    bit isb, tk;
    logic [AW-1:0] tgt, held;
    model(b0, b1, b2, pc, f, isb, tk, tgt);
    @(negedge clk_i);
    op0_i = b0; op1_i = b1; op2_i = b2; pc_i = pc;
    {flag_z_i, flag_n_i, flag_c_i, flag_v_i} = f;
    valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    // R2: result due one edge after the strobe
    chk(valid_o === 1'b1, "R2", AW'(valid_o), 1);
    chk(is_branch_o === isb && taken_o === tk && target_o === tgt, req,
        {is_branch_o, taken_o, target_o[AW-3:0]}, {isb, tk, tgt[AW-3:0]});
    held = target_o;
    // R11: scramble inputs while idle
    op0_i = ~b0; pc_i = ~pc; flag_z_i = ~flag_z_i;
    @(negedge clk_i);
    chk(valid_o === 1'b0 && target_o === held && is_branch_o === isb && taken_o === tk,
        "R11", target_o, held);
  endtask

  initial begin
    #1;
    chk(valid_o === 0 && is_branch_o === 0 && taken_o === 0 && target_o === '0, "R1", target_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(valid_o === 0 && target_o === '0, "R1", target_o, '0);

    // R3 R4 R5 R6 R10: every first byte against every flag combination
    for (int op = 0; op < 256; op++)
      for (int f = 0; f < 16; f++)
        run(8'(op), 8'(op * 7 + f), 8'h55, 32'h0001_0000 + AW'(op * 16), 4'(f),
            (op >= 8'hC0 && op <= 8'hCA) ? "R3_R4_R5_R6" : "R10");

    // R7 R10: every byte after the prefix
    for (int b1 = 0; b1 < 256; b1++)
      for (int f = 0; f < 16; f++)
        run(8'hF8, 8'(b1), 8'(b1 ^ 8'hA3), 32'h0200_0000 + AW'(b1), 4'(f), "R7");

    // R8 R9: displacement sweeps with wraparound at both ends
    for (int d = 0; d < 256; d++) begin
      run(8'hCA, 8'(d), 8'h00, 32'hFFFF_FFF0, 4'h0, "R8");
      run(8'hCA, 8'(d), 8'h00, 32'h0000_0010, 4'h0, "R8");
      run(8'hF8, 8'hE9, 8'(d), 32'h0000_0004, 4'h1, "R8");
      run(8'hC8, 8'(d), 8'h00, 32'hFFFF_FFFF, 4'h0, "R9");
      run(8'hF8, 8'hEB, 8'(d), 32'hFFFF_FFFE, 4'h0, "R9");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule